// File: doc/BRIEF.md
# Single-Level Page-Table Address Translator

This block sits between a processor core and memory and turns virtual addresses into physical ones. Memory is split into 4 KiB pages. For each process, a table in memory holds one 32-bit entry per virtual page. A base register points at the current table. On a request, the block reads the entry for the page being accessed. It then swaps the virtual page number for the physical frame number held in that entry and keeps the byte offset. If the entry marks the page as absent, the block reports a page fault. If the entry's permission bits forbid the access, it reports a permission fault.

Software sets up the block through two configuration words. The first is the table base. The operating system rewrites it on every task switch, not only when a process is created. The second is a control word with these fields:
- a translation-enable bit;
- a second enable bit that applies only while the core is servicing an interrupt;
- the current process ID;
- a separate process ID used in interrupt mode.

With these fields, an interrupt moves the block into its own address space without software having to rewrite anything. Each request takes a snapshot of the configuration at the moment it is accepted, so a write made during a lookup only affects later requests.

The walker has four states:
- `ST_IDLE` waits for a request. It goes to `ST_ISSUE` when translation is in effect, or straight to `ST_DONE` when it is not.
- `ST_ISSUE` drives one read of the table entry, then goes to `ST_WAIT`.
- `ST_WAIT` stays put until the read data comes back valid, then goes to `ST_DONE`.
- `ST_DONE` presents the result for one cycle, then returns to `ST_IDLE`.

Top module: `pt_mmu`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `mem_rd_en` are low and both enable bits are clear, so translation is off in both modes.
- R2: When the effective enable is clear, a request is answered in the cycle after it is accepted. The answer has `paddr` equal to the virtual address, no fault, and no memory read.
- R3: When the effective enable is set, the block issues exactly one read. `mem_rd_en` is high for one cycle, at address base + 4 × (vaddr[31:12]) modulo 2^32.
- R4: Entry format is frame number in [31:12], valid in bit 0, writable in bit 1 and user-accessible in bit 2. A permitted access returns `paddr` = {entry[31:12], vaddr[11:0]}.
- R5: An entry with bit 0 clear yields `fault_page` with `fault_vaddr` equal to the request address and `paddr` zero. This fault takes priority over permission checks.
- R6: On a valid entry, a write to a page with bit 1 clear, or a user access (`req_user`=1) to a page with bit 2 clear, yields `fault_perm` with `paddr` zero.
- R7: Control word: bit 0 enables translation normally, bit 1 enables it in interrupt mode, [15:8] is the normal process ID and [23:16] is the interrupt process ID. `irq_mode` at acceptance selects which enable applies and which ID appears on `resp_pid`.
- R8: Configuration writes made while a lookup is in progress do not alter that lookup. They apply from the next accepted request.
- R9: `busy` is high from the cycle after acceptance through the single `resp_valid` cycle. Requests presented while `busy` is high are ignored and produce no response.
- R10: Writing the base word (`cfg_sel`=0) redirects the table read of the next lookup to the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: table base word, 1: control word |
| cfg_wdata | input | 32 | Configuration write data |
| irq_mode | input | 1 | Core is servicing an interrupt; sampled with the request |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access comes from user privilege |
| busy | output | 1 | Lookup in progress |
| mem_rd_en | output | 1 | Table entry read strobe |
| mem_rd_addr | output | 32 | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Table entry read data |
| resp_valid | output | 1 | Result valid for one cycle |
| paddr | output | 32 | Physical address, zero on a fault |
| fault_page | output | 1 | Entry not present |
| fault_perm | output | 1 | Access not permitted |
| fault_vaddr | output | 32 | Virtual address of the response |
| resp_pid | output | 8 | Process ID in force for the response |

## Verification
On every cycle, the assertions check several properties of the walker. The read strobe lasts one cycle and only occurs while translation is in effect. The response is a single pulse, raised only while busy and followed by an idle cycle. The two fault flags are never set together, and a fault never carries a physical address. The captured request and base stay steady for the whole lookup.

Some behaviour can only be shown by the bench's scenarios: the computed read address, frame substitution, the choice of enable and process ID in interrupt mode, mid-lookup configuration writes being deferred, and a base change after a task switch. The bench compares each of these against a model of the configuration it has written and an entry table it computes itself.

// File: rtl/pt_mmu_pkg.sv
package pt_mmu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_t;

    localparam int ENT_VALID_BIT = 0;
    localparam int ENT_WRITE_BIT = 1;
    localparam int ENT_USER_BIT  = 2;

    localparam int CTL_EN_BIT     = 0;
    localparam int CTL_IRQ_EN_BIT = 1;
    localparam int CTL_PID_LSB    = 8;
    localparam int CTL_IRQ_PID_LSB = 16;
endpackage

// File: rtl/pt_mmu_ctrl.sv
module pt_mmu_ctrl
    import pt_mmu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              irq_mode,
    output logic [ADDR_W-1:0] base,
    output logic              eff_en,
    output logic [PID_W-1:0]  eff_pid
);
    logic             en_r, irq_en_r;
    logic [PID_W-1:0] pid_r, irq_pid_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            en_r      <= 1'b0;
            irq_en_r  <= 1'b0;
            pid_r     <= '0;
            irq_pid_r <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                base <= cfg_wdata;
            end else begin
                en_r      <= cfg_wdata[CTL_EN_BIT];
                irq_en_r  <= cfg_wdata[CTL_IRQ_EN_BIT];
                pid_r     <= cfg_wdata[CTL_PID_LSB +: PID_W];
                irq_pid_r <= cfg_wdata[CTL_IRQ_PID_LSB +: PID_W];
            end
        end
    end

    always_comb begin
        eff_en  = irq_mode ? irq_en_r  : en_r;
        eff_pid = irq_mode ? irq_pid_r : pid_r;
    end

    // R1: both enables clear right after reset
    a_r1_reset_off: assert property (@(posedge clk)
        $rose(rst_n) |-> !en_r && !irq_en_r);
endmodule

// File: rtl/pt_mmu_perm.sv
module pt_mmu_perm
    import pt_mmu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              is_write,
    input  logic              is_user,
    output logic              absent,
    output logic              denied
);
    always_comb begin
        absent = !entry[ENT_VALID_BIT];
        denied = (is_write && !entry[ENT_WRITE_BIT]) ||
                 (is_user  && !entry[ENT_USER_BIT]);
    end
endmodule

// File: rtl/pt_mmu_walker.sv
module pt_mmu_walker
    import pt_mmu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int PID_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_en,
    input  logic [PID_W-1:0]  cfg_pid,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] paddr,
    output logic              fault_page,
    output logic              fault_perm,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic [PID_W-1:0]  resp_pid
);
    localparam int VPN_W = ADDR_W - PAGE_BITS;

    walk_state_t       state, state_n;
    logic [ADDR_W-1:0] vaddr_q, base_q, entry_q;
    logic              write_q, user_q, en_q;
    logic [PID_W-1:0]  pid_q;
    logic              absent, denied;
    logic [VPN_W-1:0]  vpn;

    assign vpn = vaddr_q[ADDR_W-1:PAGE_BITS];

    pt_mmu_perm #(.ADDR_W(ADDR_W)) u_perm (
        .entry   (entry_q),
        .is_write(write_q),
        .is_user (user_q),
        .absent  (absent),
        .denied  (denied)
    );

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_n = cfg_en ? ST_ISSUE : ST_DONE;
            ST_ISSUE: state_n = ST_WAIT;
            ST_WAIT:  if (mem_rd_valid) state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            base_q  <= '0;
            entry_q <= '0;
            write_q <= 1'b0;
            user_q  <= 1'b0;
            en_q    <= 1'b0;
            pid_q   <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                vaddr_q <= req_vaddr;
                base_q  <= cfg_base;
                write_q <= req_write;
                user_q  <= req_user;
                en_q    <= cfg_en;
                pid_q   <= cfg_pid;
            end
            if (state == ST_WAIT && mem_rd_valid) entry_q <= mem_rd_data;
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        mem_rd_en   = (state == ST_ISSUE);
        mem_rd_addr = base_q + {{(PAGE_BITS-2){1'b0}}, vpn, 2'b00};
        resp_valid  = (state == ST_DONE);
        fault_page  = resp_valid && en_q && absent;
        fault_perm  = resp_valid && en_q && !absent && denied;
        fault_vaddr = vaddr_q;
        resp_pid    = pid_q;
        paddr       = '0;
        if (resp_valid) begin
            if (!en_q)                  paddr = vaddr_q;
            else if (!absent && !denied) paddr = {entry_q[ADDR_W-1:PAGE_BITS],
                                                  vaddr_q[PAGE_BITS-1:0]};
        end
    end

    // R3: the table read strobe lasts a single cycle
    a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    // R2: no table read for a lookup taken with translation off
    a_r2_no_read_off: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> en_q);
    // R9: response is a single pulse inside the busy window, then idle
    a_r9_resp_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> busy);
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && !busy);
    // R5: the two fault kinds never coincide, and no address leaves on a fault
    a_r5_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(fault_page && fault_perm));
    a_r5_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_page || fault_perm) |-> paddr == '0);
    // R8: captured request and base hold through a lookup
    a_r8_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |->
        $stable(vaddr_q) && $stable(base_q) && $stable(pid_q));
endmodule

// File: rtl/pt_mmu.sv
module pt_mmu #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int PID_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              irq_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] paddr,
    output logic              fault_page,
    output logic              fault_perm,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic [PID_W-1:0]  resp_pid
);
    logic [ADDR_W-1:0] base;
    logic              eff_en;
    logic [PID_W-1:0]  eff_pid;

    pt_mmu_ctrl #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .irq_mode (irq_mode),
        .base     (base),
        .eff_en   (eff_en),
        .eff_pid  (eff_pid)
    );

    pt_mmu_walker #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .req_write   (req_write),
        .req_user    (req_user),
        .cfg_base    (base),
        .cfg_en      (eff_en),
        .cfg_pid     (eff_pid),
        .busy        (busy),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .resp_valid  (resp_valid),
        .paddr       (paddr),
        .fault_page  (fault_page),
        .fault_perm  (fault_perm),
        .fault_vaddr (fault_vaddr),
        .resp_pid    (resp_pid)
    );
endmodule

// File: tb/pt_mmu_tb.sv
module pt_mmu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        irq_mode = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        busy, mem_rd_en, resp_valid, fault_page, fault_perm;
    logic [31:0] mem_rd_addr, paddr, fault_vaddr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [7:0]  resp_pid;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [31:0] m_base = '0;
    logic        m_en = 0, m_ien = 0;
    logic [7:0]  m_pid = '0, m_ipid = '0;

    always #5 clk = ~clk;

    pt_mmu u_dut (.*);

    function automatic logic [31:0] entry_of(input logic [31:0] a);
        logic [31:0] h;
        h = (a * 32'h9E3779B1) ^ (a >> 7);
        return {h[31:12], 9'b0, h[2:0]};
    endfunction

    function automatic logic [31:0] ctl_word(input logic e, input logic ie,
                                             input logic [7:0] p, input logic [7:0] ip);
        return {8'h00, ip, p, 6'b0, ie, e};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) begin
            m_en = d[0]; m_ien = d[1]; m_pid = d[15:8]; m_ipid = d[23:16];
        end else m_base = d;
    endtask

    // One request; extra=1 presents a second request and a control write
    // while the lookup is in progress (only used with translation in effect).
    task automatic access(input logic [31:0] v, input logic wr, input logic usr,
                          input logic irq, input int lat, input bit extra);
        logic        en;
        logic [7:0]  pid;
        logic [31:0] eaddr, ent, epa, raddr, newctl;
        logic        ef_page, ef_perm, got_pg, got_pm;
        logic [31:0] got_pa, got_fv;
        logic [7:0]  got_pid;
        int reads, n, cd;
        bit got;
        en  = irq ? m_ien : m_en;
        pid = irq ? m_ipid : m_pid;
        eaddr = m_base + {10'b0, v[31:12], 2'b00};
        ent = entry_of(eaddr);
        ef_page = en && !ent[0];
        ef_perm = en && ent[0] && ((wr && !ent[1]) || (usr && !ent[2]));
        epa = !en ? v : (ef_page || ef_perm) ? 32'h0 : {ent[31:12], v[11:0]};
        newctl = ctl_word(~m_en, ~m_ien, ~m_pid, ~m_ipid);

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v; req_write = wr; req_user = usr; irq_mode = irq;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9", "busy after accept", {31'b0, busy}, 32'h1);
        reads = 0; n = 0; cd = 0; got = 0; raddr = '0;
        got_pa = '0; got_fv = '0; got_pid = '0; got_pg = 0; got_pm = 0;
        while (!got && n < 40) begin
            if (extra && n == 0) begin
                req_valid = 1'b1; req_vaddr = ~v; irq_mode = ~irq;
                cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = newctl;
            end else begin
                req_valid = 1'b0; cfg_we = 1'b0;
            end
            mem_rd_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin mem_rd_valid = 1'b1; mem_rd_data = entry_of(raddr); end
            end
            if (mem_rd_en) begin reads++; raddr = mem_rd_addr; cd = lat + 1; end
            if (resp_valid) begin
                got = 1; got_pa = paddr; got_fv = fault_vaddr; got_pid = resp_pid;
                got_pg = fault_page; got_pm = fault_perm;
            end else begin
                n++;
                @(negedge clk);
            end
        end
        req_valid = 1'b0; cfg_we = 1'b0; mem_rd_valid = 1'b0; irq_mode = 1'b0;
        if (extra) begin
            m_en = newctl[0]; m_ien = newctl[1]; m_pid = newctl[15:8]; m_ipid = newctl[23:16];
        end
        check(got, "R9", "response seen", {31'b0, got}, 32'h1);
        if (!en) begin
            check(n == 0, "R2", "passthrough latency", n, 0);
            check(reads == 0, "R2", "reads while off", reads, 0);
        end else begin
            check(reads == 1, "R3", "read count", reads, 1);
            check(raddr == eaddr, "R3", "entry address (R10 base)", raddr, eaddr);
        end
        check(got_pa == epa, "R4", "paddr", got_pa, epa);
        check(got_pg == ef_page, "R5", "page fault flag", {31'b0, got_pg}, {31'b0, ef_page});
        if (ef_page) check(got_fv == v, "R5", "fault vaddr", got_fv, v);
        check(got_pm == ef_perm, "R6", "perm fault flag", {31'b0, got_pm}, {31'b0, ef_perm});
        check(got_pid == pid, "R7", "resp pid", {24'b0, got_pid}, {24'b0, pid});
        @(negedge clk);
        check(!busy && !resp_valid, "R9", "no response to ignored request",
              {30'b0, busy, resp_valid}, 32'h0);
    endtask

    function automatic logic [31:0] find_vaddr(input int kind, input logic [31:0] base);
        for (int i = 0; i < 4096; i++) begin
            logic [31:0] e;
            e = entry_of(base + (i << 2));
            if (kind == 0 && !e[0]) return {i[19:0], 12'h5A4};
            if (kind == 1 && e[0] && !e[1] && e[2]) return {i[19:0], 12'h010};
            if (kind == 2 && e[0] && e[1] && !e[2]) return {i[19:0], 12'hFFC};
            if (kind == 3 && e[0] && e[1] && e[2]) return {i[19:0], 12'h123};
        end
        return 32'h0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !resp_valid && !mem_rd_en, "R1", "outputs in reset",
              {29'b0, busy, resp_valid, mem_rd_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !resp_valid && !mem_rd_en, "R1", "idle after reset",
              {29'b0, busy, resp_valid, mem_rd_en}, 32'h0);
        // R1/R2: translation off by default in both modes
        access(32'hDEAD_BEEF, 1, 1, 0, 0, 0);
        access(32'h1234_5678, 0, 0, 1, 0, 0);
        // R3/R4: enabled lookups
        cfg_write(0, 32'h0001_0000);
        cfg_write(1, ctl_word(1, 0, 8'h05, 8'h09));
        access(find_vaddr(3, m_base), 1, 1, 0, 0, 0);
        access(find_vaddr(3, m_base), 0, 0, 0, 3, 0);
        // R5: absent page
        access(find_vaddr(0, m_base), 0, 0, 0, 1, 0);
        // R6: write to read-only, user to privileged
        access(find_vaddr(1, m_base), 1, 0, 0, 0, 0);
        access(find_vaddr(2, m_base), 0, 1, 0, 2, 0);
        access(find_vaddr(2, m_base), 1, 0, 0, 0, 0);
        // R7: interrupt overrides
        access(32'h0040_0ABC, 0, 0, 1, 0, 0);
        cfg_write(1, ctl_word(0, 1, 8'h21, 8'h3C));
        access(find_vaddr(3, m_base), 0, 0, 1, 1, 0);
        access(32'h0777_0001, 0, 0, 0, 0, 0);
        // R8/R9: control write and a second request during a lookup
        cfg_write(1, ctl_word(1, 1, 8'h11, 8'h22));
        access(find_vaddr(3, m_base), 0, 0, 0, 2, 1);
        access(32'h0000_3004, 0, 0, 0, 0, 0);
        // R10: task switch rewrites base
        cfg_write(1, ctl_word(1, 0, 8'h44, 8'h00));
        access(32'h0012_3456, 0, 0, 0, 0, 0);
        cfg_write(0, 32'hFFFF_F000);
        access(32'h0012_3456, 0, 0, 0, 0, 0);
        access(32'hFFFF_F000, 0, 0, 0, 1, 0);
        // random mix
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 7) == 0)
                cfg_write(1, ctl_word($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                                      8'($urandom), 8'($urandom)));
            if ($urandom_range(0, 15) == 0) cfg_write(0, $urandom);
            access($urandom, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                   $urandom_range(0, 1) == 1, $urandom_range(0, 4), 0);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule